// File: doc/BRIEF.md
# Two-Wire Register Access Slave with Auto-Increment

This block is a two-wire serial slave. It gives an external master read and write access to a bank of byte-wide control registers. The system clock oversamples the SCL and SDA lines and detects start, repeated start and stop conditions. The slave matches its 7-bit address. On a write transaction, the first byte after the address loads a register pointer, and each following byte is stored at the pointer.

A read has no address phase of its own. The master first writes the pointer. It then issues a repeated start, or a later new transaction, with the read bit set, and bytes are returned from the stored pointer onward. The pointer advances after every byte in both directions, wraps at the end of the bank, and is kept between transactions. SDA is driven in open-drain fashion: the `sda_oe_o` output pulls the line low when high, and the line is released otherwise.

Top module: `twi_regbank_slave`

## Requirements
- R1: After reset every register reads 0x00 and SDA is released (`sda_oe_o` = 0).
- R2: A write transaction stores the first data byte at the pointer set by the byte that follows the address. The transaction is start, address with R/W bit (bit 0 of the address byte) = 0, pointer byte, data, stop. The stored value is visible on `regs_o[8*i +: 8]` for register i.
- R3: Each written data byte advances the pointer by one, so a burst of N bytes fills base through base+N-1. The pointer wraps from NUM_REGS-1 to 0.
- R4: The slave pulls SDA low during the ninth clock after each of these bytes: a matching address byte, the pointer byte, and each written data byte.
- R5: A transaction with a non-matching address gets no acknowledge on any byte. Data bytes that follow it leave the registers unchanged.
- R6: After the pointer is written, a repeated start and an address with R/W = 1 return the register at the pointer, most significant bit first.
- R7: A read burst returns consecutive registers and advances the pointer after every byte, wrapping from NUM_REGS-1 to 0.
- R8: A NACK (SDA high on the ninth clock of a read byte) ends the burst. The slave then keeps SDA released through any further clocks until a start or stop.
- R9: The pointer survives a stop. A new transaction that begins with a read address continues at the register after the last one transferred.
- R10: A start condition that arrives in the middle of a byte aborts that byte, which writes nothing, and restarts address reception.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| regs_o | output | NUM_REGS*8 | Flat view of the register bank, register i at bits 8*i+7:8*i |

## Verification
Two events can land on the same falling SCL edge. The first is storing a data byte while the pointer advances past the last register. The second is loading the next read byte while the pointer increments and wraps. Both are provoked by bursts that start two registers below the end of the bank. A scoreboard compares each read byte against the values written earlier, so a lost increment or a wrong wrap shows up as a mismatch. A repeated start in the middle of a byte is also forced, which places restart handling where a byte would otherwise be stored. The bench then checks that the interrupted register keeps its old value.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } twi_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 4;
endpackage

// File: rtl/twi_sync_edge.sv
module twi_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  // bus idles high, so reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], line_i};
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [7:0]            wdata_i,
  input  logic                  ptr_ld_i,
  input  logic [AW-1:0]         ptr_val_i,
  input  logic                  ptr_inc_i,
  output logic [AW-1:0]         ptr_o,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  logic [AW-1:0] ptr_q;
  logic [7:0]    bank [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (ptr_ld_i)  ptr_q <= ptr_val_i;
    else if (ptr_inc_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               bank[i] <= '0;
      else if (wr_en_i && ptr_q == AW'(i))       bank[i] <= wdata_i;
    end
    assign regs_o[8*i +: 8] = bank[i];
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = bank[ptr_q];
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR = 7'h4C,
  parameter int unsigned AW         = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_lvl_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_lvl_i,
  input  logic             sda_rise_i,
  input  logic             sda_fall_i,
  input  logic [7:0]       rdata_i,
  output logic             wr_en_o,
  output logic [7:0]       wdata_o,
  output logic             ptr_ld_o,
  output logic [AW-1:0]    ptr_val_o,
  output logic             ptr_inc_o,
  output logic             sda_oe_o,
  output logic             start_o,
  output logic             stop_o,
  output twi_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o
);
  twi_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sh_q, tx_q;
  logic             ack_q, rd_drv_q, rw_q, mnack_q;
  logic             start, stop, byte_end, ack_end, load_tx, dev_match;

  assign start     = sda_fall_i & scl_lvl_i;
  assign stop      = sda_rise_i & scl_lvl_i;
  assign byte_end  = scl_fall_i && cnt_q == CNT_W'(8);
  assign ack_end   = scl_fall_i && cnt_q == CNT_W'(9);
  assign dev_match = sh_q[7:1] == SLAVE_ADDR;

  always_comb begin
    wr_en_o   = !start && !stop && state_q == ST_WDATA && byte_end;
    ptr_ld_o  = !start && !stop && state_q == ST_PTR && byte_end;
    load_tx   = !start && !stop && ack_end &&
                ((state_q == ST_DEV && rw_q) || (state_q == ST_RDATA && !mnack_q));
    ptr_inc_o = wr_en_o | load_tx;
  end

  assign wdata_o   = sh_q;
  assign ptr_val_o = sh_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      ack_q    <= 1'b0;
      rd_drv_q <= 1'b0;
      rw_q     <= 1'b0;
      mnack_q  <= 1'b1;
    end else if (start || stop) begin
      state_q  <= start ? ST_DEV : ST_IDLE;
      cnt_q    <= '0;
      ack_q    <= 1'b0;
      rd_drv_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_PTR, ST_WDATA: begin
          if (scl_rise_i && cnt_q < CNT_W'(9)) begin
            if (cnt_q < CNT_W'(8)) sh_q <= {sh_q[6:0], sda_lvl_i};
            cnt_q <= cnt_q + 1'b1;
          end
          if (byte_end) begin
            if (state_q != ST_DEV || dev_match) ack_q <= 1'b1;
            else                                state_q <= ST_WAIT;
            if (state_q == ST_DEV) rw_q <= sh_q[0];
          end
          if (ack_end) begin
            ack_q <= 1'b0;
            cnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (rw_q) begin
                state_q  <= ST_RDATA;
                tx_q     <= rdata_i;
                rd_drv_q <= ~rdata_i[7];
              end else begin
                state_q <= ST_PTR;
              end
            end else begin
              state_q <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise_i && cnt_q < CNT_W'(9)) begin
            if (cnt_q == CNT_W'(8)) mnack_q <= sda_lvl_i;
            cnt_q <= cnt_q + 1'b1;
          end
          if (scl_fall_i) begin
            if (cnt_q != '0 && cnt_q < CNT_W'(8)) begin
              tx_q     <= {tx_q[6:0], 1'b0};
              rd_drv_q <= ~tx_q[6];
            end else if (cnt_q == CNT_W'(8)) begin
              rd_drv_q <= 1'b0;  // master owns the ack slot
            end else if (cnt_q == CNT_W'(9)) begin
              cnt_q <= '0;
              if (mnack_q) begin
                state_q <= ST_WAIT;
              end else begin
                tx_q     <= rdata_i;
                rd_drv_q <= ~rdata_i[7];
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = ack_q | rd_drv_q;
  assign start_o  = start;
  assign stop_o   = stop;
  assign state_o  = state_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave
  import twi_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR = 7'h4C,
  parameter int unsigned NUM_REGS   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int unsigned AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    twi_sync_edge #(.STAGES(2)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  logic             wr_en, ptr_ld, ptr_inc, start, stop;
  logic [7:0]       wdata, rdata;
  logic [AW-1:0]    ptr_val, ptr;
  twi_state_e       state;
  logic [CNT_W-1:0] cnt;

  twi_slave_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .AW(AW)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_lvl_i (lvl[0]),
    .scl_rise_i(rise[0]),
    .scl_fall_i(fall[0]),
    .sda_lvl_i (lvl[1]),
    .sda_rise_i(rise[1]),
    .sda_fall_i(fall[1]),
    .rdata_i   (rdata),
    .wr_en_o   (wr_en),
    .wdata_o   (wdata),
    .ptr_ld_o  (ptr_ld),
    .ptr_val_o (ptr_val),
    .ptr_inc_o (ptr_inc),
    .sda_oe_o  (sda_oe_o),
    .start_o   (start),
    .stop_o    (stop),
    .state_o   (state),
    .cnt_o     (cnt)
  );

  twi_regfile #(.NUM_REGS(NUM_REGS), .AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wdata_i  (wdata),
    .ptr_ld_i (ptr_ld),
    .ptr_val_i(ptr_val),
    .ptr_inc_i(ptr_inc),
    .ptr_o    (ptr),
    .rdata_o  (rdata),
    .regs_o   (regs_o)
  );
endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk
  import twi_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned AW       = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_lvl_i,
  input logic                  start_i,
  input logic                  stop_i,
  input logic                  sda_oe_i,
  input twi_state_e            state_i,
  input logic [CNT_W-1:0]      cnt_i,
  input logic                  wr_en_i,
  input logic [7:0]            wdata_i,
  input logic [AW-1:0]         ptr_i,
  input logic [NUM_REGS*8-1:0] regs_i
);
  logic          wr_q;
  logic [AW-1:0] wp_q;
  logic [7:0]    wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0;
      wp_q <= '0;
      wd_q <= '0;
    end else begin
      wr_q <= wr_en_i;
      wp_q <= ptr_i;
      wd_q <= wdata_i;
    end
  end

  // R2
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> regs_i[int'(wp_q)*8 +: 8] == wd_q);

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ptr_i == (($past(ptr_i) == AW'(NUM_REGS-1)) ? '0 : $past(ptr_i) + 1'b1));

  // R5
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE || state_i == ST_WAIT) |-> !sda_oe_i);

  // R10
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> state_i == ST_DEV && cnt_i == '0 && !sda_oe_i);

  // R11
  drive_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sda_oe_i) |-> (!$past(scl_lvl_i) || $past(start_i) || $past(stop_i)));
endmodule

bind twi_regbank_slave twi_slave_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_lvl_i(lvl[0]),
  .start_i  (start),
  .stop_i   (stop),
  .sda_oe_i (sda_oe_o),
  .state_i  (state),
  .cnt_i    (cnt),
  .wr_en_i  (wr_en),
  .wdata_i  (wdata),
  .ptr_i    (ptr),
  .regs_i   (regs_o)
);

// File: tb/tb_twi_regbank_slave.sv
`timescale 1ns/1ps
module tb_twi_regbank_slave;
  localparam int NREG = 32;
  localparam logic [6:0] ADR = 7'h4C;
  localparam int Q = 10;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  twi_regbank_slave #(.SLAVE_ADDR(ADR), .NUM_REGS(NREG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$], got_q[$];
  string      req_q[$];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      automatic logic [7:0] g = got_q.pop_front();
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string r = req_q.pop_front();
      chk(r, g, e);
    end
  end

  // R11: drive may only change with SCL low
  int  r11_bad = 0;
  logic oe_prev = 0, scl_prev = 1;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_oe !== oe_prev) r11_bad++;
    oe_prev  <= sda_oe;
    scl_prev <= scl_m;
  end

  task automatic expect_rd(string r, logic [7:0] v);
    exp_q.push_back(v); req_q.push_back(r);
  endtask

  task automatic bus_start();
    sda_m = 1; hold(Q); scl_m = 1; hold(Q); sda_m = 0; hold(Q); scl_m = 0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; hold(Q); scl_m = 1; hold(Q); sda_m = 1; hold(Q);
  endtask

  task automatic send_bits(int n, logic [7:0] b);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hold(Q); scl_m = 1; hold(2*Q); scl_m = 0; hold(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(8, b);
    sda_m = 1; hold(Q); scl_m = 1; hold(Q); ack = sda_bus; hold(Q); scl_m = 0; hold(Q);
  endtask

  task automatic recv_byte(logic nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); scl_m = 1; hold(Q); b[i] = sda_bus; hold(Q); scl_m = 0;
    end
    hold(Q); sda_m = nack; hold(Q); scl_m = 1; hold(2*Q); scl_m = 0; hold(Q); sda_m = 1;
    got_q.push_back(b);
  endtask

  task automatic wr_burst(string r, logic [7:0] base, logic [7:0] d[$]);
    logic a;
    bus_start();
    send_byte({ADR, 1'b0}, a); chk({r, " R4 addr ack"}, a, 0);
    send_byte(base, a);        chk({r, " R4 ptr ack"}, a, 0);
    foreach (d[k]) begin
      send_byte(d[k], a);      chk({r, " R4 data ack"}, a, 0);
    end
    bus_stop();
  endtask

  task automatic drain();
    hold(5);
    chk("scoreboard drained", exp_q.size() + got_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] b;
    int oe_hits;
    hold(5); rst_n = 1; hold(5);
    // R1
    chk("R1 sda released", sda_oe, 0);
    chk("R1 regs zero", (regs == '0), 1);

    // R2 single write
    wr_burst("R2", 8'd5, '{8'hA5});
    chk("R2 reg5", rg(5), 8'hA5);

    // R3 burst across wrap
    wr_burst("R3", 8'd30, '{8'h11, 8'h22, 8'h33, 8'h44});
    chk("R3 reg30", rg(30), 8'h11);
    chk("R3 reg31", rg(31), 8'h22);
    chk("R3 reg0 wrap", rg(0), 8'h33);
    chk("R3 reg1", rg(1), 8'h44);
    wr_burst("R9 setup", 8'd2, '{8'h5E});

    // R6 read one via repeated start
    bus_start();
    send_byte({ADR, 1'b0}, a); send_byte(8'd5, a);
    bus_start();
    send_byte({ADR, 1'b1}, a); chk("R4 read addr ack", a, 0);
    expect_rd("R6 read base", 8'hA5);
    recv_byte(1'b1, b);
    bus_stop();
    drain();

    // R7 burst read wrapping
    bus_start();
    send_byte({ADR, 1'b0}, a); send_byte(8'd30, a);
    bus_start();
    send_byte({ADR, 1'b1}, a);
    expect_rd("R7 r30", 8'h11); recv_byte(1'b0, b);
    expect_rd("R7 r31", 8'h22); recv_byte(1'b0, b);
    expect_rd("R7 r0",  8'h33); recv_byte(1'b0, b);
    expect_rd("R7 r1",  8'h44); recv_byte(1'b1, b);
    // R8: extra clocks after NACK must see SDA released
    oe_hits = 0;
    for (int i = 0; i < 9; i++) begin
      hold(Q); scl_m = 1;
      for (int k = 0; k < Q; k++) begin hold(1); if (sda_oe) oe_hits++; end
      scl_m = 0;
      for (int k = 0; k < Q; k++) begin hold(1); if (sda_oe) oe_hits++; end
    end
    chk("R8 released after NACK", oe_hits, 0);
    bus_stop();
    drain();

    // R9 pointer kept across stop: next is reg2
    bus_start();
    send_byte({ADR, 1'b1}, a);
    expect_rd("R9 continue", 8'h5E); recv_byte(1'b1, b);
    bus_stop();
    drain();

    // R5 wrong address
    bus_start();
    send_byte({ADR ^ 7'h01, 1'b0}, a); chk("R5 addr nack", a, 1);
    send_byte(8'd5, a);                chk("R5 ptr nack", a, 1);
    send_byte(8'hFF, a);               chk("R5 data nack", a, 1);
    bus_stop();
    chk("R5 reg5 kept", rg(5), 8'hA5);

    // R10 start mid-byte
    bus_start();
    send_byte({ADR, 1'b0}, a); send_byte(8'd7, a);
    send_bits(3, 8'hFF);
    bus_start();
    send_byte({ADR, 1'b0}, a); chk("R10 addr ack after restart", a, 0);
    send_byte(8'd8, a); send_byte(8'h3C, a);
    bus_stop();
    chk("R10 reg7 untouched", rg(7), 8'h00);
    chk("R10 reg8", rg(8), 8'h3C);

    chk("R11 drive changes with SCL high", r11_bad, 0);
    finish_run();
  end
endmodule